// File: doc/BRIEF.md
# SPI Block-Write Data Packetizer

This block drives the data phase of a host-side block write over SPI. After the command frame that opens an extended write has gone out, the host starts the packetizer with a byte count. The packetizer cuts the payload into packets of at most 8192 bytes. Each packet goes to the SPI shifter as a header byte, then the payload bytes taken from an input byte stream, then an optional pair of CRC bytes. The CRC bytes are sent as zeros, because the data CRC is not checked on this path.

The header tells the far side where the packet sits in the transfer. Its low two bits carry a position code: start, middle, or last. The code comes from how many bytes remain when the packet begins. No response is awaited between packets, so the next header follows the previous packet's last byte at once. Both byte streams use valid/ready flow control, and a pass-through path joins the input stream to the output stream during payload bytes. Requests for four bytes or fewer are refused and nothing is sent.

Top module: `spi_block_packetizer`

## Requirements
- R1: A header byte is 0xF0 with a 2-bit position code in bits 1:0. The code is 3 whenever the bytes remaining at the start of that packet are 8192 or fewer.
- R2: When more than 8192 bytes remain at the start of a packet, the code is 1 for the first packet of the transfer and 2 for any later packet.
- R3: Each packet carries min(remaining, 8192) payload bytes. The payload bytes appear on the output in the same order they were accepted from the input stream.
- R4: With `crc_en` sampled high at start, each payload is followed by exactly two 0x00 bytes. With it low, no such bytes are sent.
- R5: The next header directly follows the last byte of the previous packet. The transfer emits exactly the sum of its packet sizes and nothing more.
- R6: A start with `xfer_len` below 5 produces a one-cycle `reject` pulse in the following cycle. `busy` stays low and no output byte is offered.
- R7: `in_ready` is high only during a payload byte while `out_ready` is high. During a payload byte, `out_valid` follows `in_valid`.
- R8: `done` pulses for one cycle, in the cycle after the handshake of the final byte. `busy` is low in that cycle.
- R9: After reset, `busy`, `done`, `reject`, `out_valid` and `in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer; accepted only while idle |
| xfer_len | input | LEN_W | Transfer length in bytes |
| crc_en | input | 1 | Append two CRC bytes per packet |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse after the final byte |
| reject | output | 1 | One-cycle pulse for a refused start |
| in_data | input | 8 | Payload byte from the source |
| in_valid | input | 1 | Payload byte available |
| in_ready | output | 1 | Payload byte consumed this cycle |
| out_data | output | 8 | Byte toward the SPI shifter |
| out_valid | output | 1 | Output byte offered |
| out_ready | input | 1 | Shifter takes the byte |

## Verification
Output bytes are combinational from the state register, and the payload path passes straight through. Every byte handshake is therefore judged in the same cycle it occurs. The bench samples one nanosecond after each falling edge, before the rising edge that commits the handshake. `done` and `reject` are registered, so each is due exactly one cycle after its cause: the final byte handshake or the start edge. The bench looks for them at the next sample point. Every handshaken output byte is compared with a value computed from its offset in the packet layout.

// File: rtl/spi_block_packetizer.sv
`timescale 1ns/1ps
module spi_block_packetizer #(
  parameter int LEN_W     = 24,
  parameter int MAX_PKT   = 8192,
  parameter int MIN_LEN   = 5,
  parameter int CRC_BYTES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic             crc_en,
  output logic             busy,
  output logic             done,
  output logic             reject,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [7:0]       out_data,
  output logic             out_valid,
  input  logic             out_ready
);

  localparam int PKT_W = $clog2(MAX_PKT + 1);
  localparam int CRC_W = $clog2(CRC_BYTES) + 1;

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_DATA, S_CRC} st_t;

  st_t              st;
  logic [LEN_W-1:0] rem;
  logic [PKT_W-1:0] pkt_left;
  logic [CRC_W-1:0] crc_cnt;
  logic             first, crc_on, done_q, reject_q;

  wire       in_hdr   = (st == S_HDR);
  wire       in_pay   = (st == S_DATA);
  wire       in_crc   = (st == S_CRC);
  wire       last_pkt = (rem <= LEN_W'(MAX_PKT));
  wire [1:0] order    = last_pkt ? 2'd3 : (first ? 2'd1 : 2'd2);

  assign out_valid = in_hdr | in_crc | (in_pay & in_valid);
  assign out_data  = in_hdr ? {6'b111100, order} : (in_pay ? in_data : 8'h00);
  assign in_ready  = in_pay & out_ready;
  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign reject    = reject_q;

  wire fire = out_valid & out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      rem      <= '0;
      pkt_left <= '0;
      crc_cnt  <= '0;
      first    <= 1'b0;
      crc_on   <= 1'b0;
      done_q   <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      reject_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (xfer_len < LEN_W'(MIN_LEN)) begin
            reject_q <= 1'b1;
          end else begin
            rem    <= xfer_len;
            first  <= 1'b1;
            crc_on <= crc_en;
            st     <= S_HDR;
          end
        end
        S_HDR: if (fire) begin
          pkt_left <= last_pkt ? PKT_W'(rem) : PKT_W'(MAX_PKT);
          first    <= 1'b0;
          st       <= S_DATA;
        end
        S_DATA: if (fire) begin
          rem      <= rem - 1'b1;
          pkt_left <= pkt_left - 1'b1;
          if (pkt_left == PKT_W'(1)) begin
            if (crc_on) begin
              crc_cnt <= '0;
              st      <= S_CRC;
            end else if (rem == LEN_W'(1)) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              st <= S_HDR;
            end
          end
        end
        S_CRC: if (fire) begin
          crc_cnt <= crc_cnt + 1'b1;
          if (crc_cnt == CRC_W'(CRC_BYTES - 1)) begin
            if (rem == '0) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              st <= S_HDR;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_block_packetizer_chk.sv
`timescale 1ns/1ps
module spi_block_packetizer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       reject,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       in_hdr
);

  AST_READY_NEEDS_SINK: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> out_ready); // R7

  AST_HDR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hdr && out_valid) |-> (out_data[7:2] == 6'b111100 && out_data[1:0] != 2'b00)); // R1

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8

  AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> !busy); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!out_valid && !in_ready)); // R6

endmodule

bind spi_block_packetizer spi_block_packetizer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .reject    (reject),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .in_hdr    (in_hdr)
);

// File: tb/spi_block_packetizer_tb.sv
`timescale 1ns/1ps
module spi_block_packetizer_tb;

  localparam int LEN_W = 24;
  localparam int MAXP  = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] xfer_len = '0;
  logic crc_en = 1'b0;
  logic busy, done, reject, in_ready, out_valid;
  logic [7:0] in_data = 8'h00;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [7:0] out_data;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  spi_block_packetizer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_len(xfer_len), .crc_en(crc_en),
    .busy(busy), .done(done), .reject(reject),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] src_byte(input int i);
    return 8'((i * 29) + (i / 256) + 3);
  endfunction

  function automatic int total_bytes(input int len, input bit crc);
    int rem = len;
    int n = 0;
    while (rem > 0) begin
      int p = (rem > MAXP) ? MAXP : rem;
      n += 1 + p + (crc ? 2 : 0);
      rem -= p;
    end
    return n;
  endfunction

  // kind: 0 header, 1 payload, 2 crc
  function automatic logic [7:0] exp_byte(input int len, input bit crc, input int k, output int kind);
    int rem = len;
    int base = 0;
    int off = k;
    bit first = 1'b1;
    kind = 0;
    while (rem > 0) begin
      int p = (rem > MAXP) ? MAXP : rem;
      int sz = 1 + p + (crc ? 2 : 0);
      if (off < sz) begin
        if (off == 0) begin
          kind = 0;
          return 8'hF0 | ((rem <= MAXP) ? 8'd3 : (first ? 8'd1 : 8'd2));
        end else if (off <= p) begin
          kind = 1;
          return src_byte(base + off - 1);
        end else begin
          kind = 2;
          return 8'h00;
        end
      end
      off -= sz;
      base += p;
      rem -= p;
      first = 1'b0;
    end
    kind = 3;
    return 8'hxx;
  endfunction

  task automatic run_xfer(input int len, input bit crc, input int rdy_pct);
    int k = 0;
    int src = 0;
    int hdr_bad = 0, pay_bad = 0, crc_bad = 0, flow_bad = 0, extra = 0;
    int tot = total_bytes(len, crc);
    int cyc = 0;
    bit seen_done = 1'b0;
    bit busy_at_done = 1'b0;
    @(negedge clk);
    start = 1'b1; xfer_len = LEN_W'(len); crc_en = crc;
    @(negedge clk);
    start = 1'b0;
    while (!seen_done && cyc < 60000) begin
      in_valid  = ($urandom % 100) < rdy_pct;
      out_ready = ($urandom % 100) < rdy_pct;
      in_data   = src_byte(src);
      #1;
      if (done) begin
        seen_done = 1'b1;
        busy_at_done = busy;
      end else begin
        if (in_ready && !out_ready) flow_bad++;
        if (out_valid && out_ready) begin
          int kind;
          logic [7:0] e;
          if (k >= tot) extra++;
          else begin
            e = exp_byte(len, crc, k, kind);
            if (out_data !== e) begin
              if (kind == 0) hdr_bad++;
              else if (kind == 1) pay_bad++;
              else crc_bad++;
              if (hdr_bad + pay_bad + crc_bad == 1)
                $display("  mismatch len=%0d at byte %0d: got %02h want %02h", len, k, out_data, e);
            end
          end
          k++;
        end
        if (in_valid && in_ready) src++;
      end
      @(negedge clk);
      cyc++;
    end
    in_valid = 1'b0; out_ready = 1'b0;
    check(hdr_bad == 0, "R1/R2 header codes", hdr_bad, 0);
    check(pay_bad == 0, "R3 payload order", pay_bad, 0);
    check(crc_bad == 0, "R4 crc bytes", crc_bad, 0);
    check(k == tot && extra == 0, "R5 byte count", k, tot);
    check(flow_bad == 0, "R7 in_ready without out_ready", flow_bad, 0);
    check(seen_done && !busy_at_done, "R8 done pulse with busy low", seen_done, 1);
    #1;
    check(!done, "R8 done is one cycle", done, 0);
  endtask

  task automatic run_reject(input int len);
    int offered = 0;
    @(negedge clk);
    start = 1'b1; xfer_len = LEN_W'(len); crc_en = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    check(reject === 1'b1 && busy === 1'b0, "R6 reject pulse", reject, 1);
    in_valid = 1'b1; out_ready = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      if (out_valid || busy || reject) offered++;
    end
    in_valid = 1'b0; out_ready = 1'b0;
    check(offered == 0, "R6 nothing sent after reject", offered, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd77));
    repeat (3) @(negedge clk);
    #1;
    check(!busy && !done && !reject && !out_valid && !in_ready, "R9 reset state",
          {busy, done, reject, out_valid, in_ready}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_reject(4);
    run_reject(0);
    run_xfer(5, 1'b0, 100);
    run_xfer(5, 1'b1, 70);
    run_xfer(8192, 1'b1, 90);
    run_xfer(8193, 1'b0, 90);
    run_xfer(16384, 1'b0, 95);
    run_xfer(17000, 1'b1, 95);
    for (int t = 0; t < 6; t++)
      run_xfer(5 + int'($urandom % 400), 1'($urandom), 60 + int'($urandom % 40));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule